// File: doc/BRIEF.md
# Ring-Token Cascade Word Transfer Stage

This block is one stage of a cascaded filter that shares a single 16-bit bidirectional bus among one master and up to six slaves. Bus ownership is handed along the chain by short active-low flag pulses, with no arbiter and no address decode. The master opens a round by driving its word and pulsing its second flag output. The first slave sees that pulse on its second flag input and captures the master's word. It then drives its own word and pulses its first flag output, which feeds the next slave's second flag input. The last slave's first flag output returns to the master's first flag input. The master captures that word and rebroadcasts it on the bus with a pulse on its first flag output, which reaches every slave's first flag input. A stage may drive the bus only while it holds the token.

The block runs on a clock at twice the system rate, so the half-system-clock flag pulse is exactly one cycle wide. The outgoing word enters through a valid/ready port with a one-word holding register: `tx_ready` is low while a word waits, and the producer must hold `tx_valid` and `tx_data` until it sees ready. The chain cannot wait for a consumer, so the receive side has no true back-pressure. `rx_valid` stays up with stable data until `rx_ready` is seen, but a word that arrives in the meantime replaces the one that has not been taken. For single-chip use, tie `flag_b_out` to `flag_a_in` and hold `flag_b_in` high.

Top module: `cxf_stage`

## Requirements
- R1: While reset is asserted or `pwr_dn` is high, both flag outputs are high and the bus is released to high impedance. During `pwr_dn`, `tx_ready` is low, and on release the stage is idle with no word pending and `rx_valid` low.
- R2: Every transfer drives the bus for exactly 4 clock cycles (two system clocks). Exactly one flag output goes low for exactly one cycle (half a system clock), in the third driven cycle, one system clock after the data starts.
- R3: A master (`is_slave`=0) drives the bus only to send an accepted `tx_data` word, with its pulse on `flag_b_out`, or to rebroadcast. Pulses on its `flag_b_in` have no effect.
- R4: A slave (`is_slave`=1) that sees a falling edge on `flag_b_in` presents the bus word on `rx_data` with `rx_bcast`=0. It then drives its held word, or 0000h if it holds none, with the pulse on `flag_a_out`. A slave never drives without this token, and its `flag_b_out` stays high.
- R5: After opening a round, a master that sees a falling edge on `flag_a_in` presents the bus word on `rx_data` with `rx_bcast`=0. It then rebroadcasts that same word with the pulse on `flag_a_out`.
- R6: A slave that sees a falling edge on `flag_a_in` presents the bus word on `rx_data` with `rx_bcast`=1.
- R7: `rx_valid` stays high with stable `rx_data` until a cycle with `rx_ready` high. A word captured before then replaces the untaken one.
- R8: The outgoing path holds one word. `tx_ready` is low from acceptance until the word is sent.
- R9: With `flag_b_out` looped to `flag_a_in` and `flag_b_in` high, a master receives its own word back with `rx_bcast`=0. It produces one pulse on each flag output.
- R10: In a chain of stages sharing the bus, no two stages drive the bus at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the system rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down: quiets outputs and clears state while high |
| is_slave | input | 1 | 0 selects the master role, 1 the slave role |
| tx_valid | input | 1 | Outgoing word offered |
| tx_ready | output | 1 | Holding register empty, word will be taken |
| tx_data | input | 16 | Outgoing word |
| rx_valid | output | 1 | Captured word available |
| rx_ready | input | 1 | Consumer takes the captured word |
| rx_data | output | 16 | Captured word |
| rx_bcast | output | 1 | 1 when the captured word came from the master's broadcast |
| cas_bus | inout | 16 | Shared bus, bit 15 most significant, high impedance when not driving |
| flag_a_in | input | 1 | First flag input, active-low pulse |
| flag_b_in | input | 1 | Second flag input, active-low pulse |
| flag_a_out | output | 1 | First flag output, active-low pulse |
| flag_b_out | output | 1 | Second flag output, active-low pulse |

## Verification
A master and three slaves are chained as a ring on one bus, and rounds run with random words and a random subset of slaves holding words. This separates a slave that forwards its own word from one that sends zero, and it exposes any mixing up of the upstream word and the broadcast word. Directed cases cover a slave holding a word with no token, a stray pulse on the master's second flag input, power-down in the middle of a transfer, a consumer that is not ready when two words arrive, and a separate single-chip loopback. A bus monitor checks the drive window, the flag position and width, and bus contention on every transfer.

// File: rtl/cxf_pkg.sv
package cxf_pkg;
  typedef enum logic [1:0] {
    CX_IDLE  = 2'd0,
    CX_WAIT  = 2'd1,
    CX_BCAST = 2'd2
  } cx_state_e;

  localparam int unsigned FLAG_A = 0;
  localparam int unsigned FLAG_B = 1;
endpackage

// File: rtl/cxf_edge_cap.sv
// Flag synchronizer with falling-edge detect; bus data is sampled in the
// same edge as the first flag stage and delayed alongside it.
module cxf_edge_cap #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         flag_n,
  input  logic [W-1:0] bus_in,
  output logic         fall,
  output logic [W-1:0] word
);
  logic [DEPTH:0] fp;
  logic [W-1:0]   dp [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   fp <= '1;
    else if (clr) fp <= '1;
    else          fp <= {fp[DEPTH-1:0], flag_n};
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_dpipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dp[k] <= '0;
      else if (k == 0) dp[k] <= bus_in;
      else dp[k] <= dp[(k == 0) ? 0 : k-1];
    end
  end

  assign fall = fp[DEPTH] & ~fp[DEPTH-1];
  assign word = dp[DEPTH-1];

  assert_single_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/cxf_burst.sv
// Drives one word for HOLD cycles and places a registered active-low pulse
// of LEN cycles, LEAD cycles after the start, on the selected flag.
module cxf_burst #(
  parameter int W    = 16,
  parameter int HOLD = 4,
  parameter int LEAD = 2,
  parameter int LEN  = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         start,
  input  logic [W-1:0] start_word,
  input  logic         start_sel,
  output logic         oe,
  output logic [W-1:0] dq,
  output logic [1:0]   flag_n,
  output logic         busy,
  output logic         done
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic          active, sel_q, last, nx_active, nx_sel, in_win;
  logic [CW-1:0] cnt, nx_cnt;
  logic [W-1:0]  word_q;
  logic [1:0]    flag_q;

  always_comb begin
    last      = active && (cnt == CW'(HOLD-1));
    nx_active = start | (active & ~last);
    nx_cnt    = start ? '0 : cnt + 1'b1;
    nx_sel    = start ? start_sel : sel_q;
    in_win    = nx_active && (int'(nx_cnt) >= LEAD) && (int'(nx_cnt) < LEAD + LEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      sel_q  <= 1'b0;
      word_q <= '0;
      flag_q <= '1;
    end else if (clr) begin
      active <= 1'b0;
      cnt    <= '0;
      sel_q  <= 1'b0;
      word_q <= '0;
      flag_q <= '1;
    end else begin
      active <= nx_active;
      cnt    <= nx_active ? nx_cnt : '0;
      sel_q  <= nx_sel;
      if (start) word_q <= start_word;
      for (int i = 0; i < 2; i++)
        flag_q[i] <= !(in_win && (nx_sel == 1'(i)));
    end
  end

  assign oe     = active;
  assign dq     = word_q;
  assign flag_n = flag_q;
  assign busy   = active;
  assign done   = last;

  assert_flag_in_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(&flag_q) |-> active);
  if (LEN == 1) begin : g_width
    assert_flag_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(&flag_q) |=> (&flag_q));
  end
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |-> !start);
endmodule

// File: rtl/cxf_stage.sv
module cxf_stage
  import cxf_pkg::*;
#(
  parameter int W          = 16,
  parameter int PHASES     = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_dn,
  input  logic         is_slave,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic [W-1:0] rx_data,
  output logic         rx_bcast,
  inout  wire  [W-1:0] cas_bus,
  input  logic         flag_a_in,
  input  logic         flag_b_in,
  output logic         flag_a_out,
  output logic         flag_b_out
);
  localparam int HOLD = 2 * PHASES;
  localparam int LEAD = PHASES;
  localparam int LEN  = (PHASES / 2 > 0) ? PHASES / 2 : 1;

  logic [1:0]   flag_in_v, fall, fl_n;
  logic [W-1:0] cap [2];
  logic [W-1:0] bus_in, dq, start_word, ld_word, out_word;
  logic         oe, busy, done, start, start_sel, pop, rx_ld, ld_bcast, out_full, tx_fire;
  cx_state_e    state, st_nx;

  assign flag_in_v = {flag_b_in, flag_a_in};
  assign bus_in    = cas_bus;

  for (genvar i = 0; i < 2; i++) begin : g_cap
    cxf_edge_cap #(.W(W), .DEPTH(SYNC_DEPTH)) u_cap (
      .clk(clk), .rst_n(rst_n), .clr(pwr_dn), .flag_n(flag_in_v[i]),
      .bus_in(bus_in), .fall(fall[i]), .word(cap[i])
    );
  end

  cxf_burst #(.W(W), .HOLD(HOLD), .LEAD(LEAD), .LEN(LEN)) u_burst (
    .clk(clk), .rst_n(rst_n), .clr(pwr_dn), .start(start), .start_word(start_word),
    .start_sel(start_sel), .oe(oe), .dq(dq), .flag_n(fl_n), .busy(busy), .done(done)
  );

  assign cas_bus    = (oe && !pwr_dn) ? dq : 'z;
  assign flag_a_out = fl_n[FLAG_A] | pwr_dn;
  assign flag_b_out = fl_n[FLAG_B] | pwr_dn;
  assign tx_ready   = !out_full && !pwr_dn;
  assign tx_fire    = tx_valid && tx_ready;

  always_comb begin
    start      = 1'b0;
    start_sel  = 1'b0;
    start_word = out_word;
    pop        = 1'b0;
    rx_ld      = 1'b0;
    ld_word    = cap[FLAG_A];
    ld_bcast   = 1'b0;
    st_nx      = state;
    if (is_slave) begin
      st_nx = CX_IDLE;
      if (fall[FLAG_B] && !busy) begin
        rx_ld      = 1'b1;
        ld_word    = cap[FLAG_B];
        start      = 1'b1;
        start_word = out_full ? out_word : '0;
        pop        = 1'b1;
      end else if (fall[FLAG_A]) begin
        rx_ld    = 1'b1;
        ld_bcast = 1'b1;
      end
    end else begin
      unique case (state)
        CX_IDLE: if (out_full && !busy) begin
          start     = 1'b1;
          start_sel = 1'b1;
          pop       = 1'b1;
          st_nx     = CX_WAIT;
        end
        CX_WAIT: if (fall[FLAG_A] && !busy) begin
          rx_ld      = 1'b1;
          start      = 1'b1;
          start_word = cap[FLAG_A];
          st_nx      = CX_BCAST;
        end
        CX_BCAST: if (done) st_nx = CX_IDLE;
        default: st_nx = CX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CX_IDLE;
      out_full <= 1'b0;
      out_word <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_bcast <= 1'b0;
    end else if (pwr_dn) begin
      state    <= CX_IDLE;
      out_full <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      state <= st_nx;
      if (pop) out_full <= 1'b0;
      if (tx_fire) begin
        out_full <= 1'b1;
        out_word <= tx_data;
      end
      if (rx_ld) begin
        rx_valid <= 1'b1;
        rx_data  <= ld_word;
        rx_bcast <= ld_bcast;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  assert_pd_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!busy && !rx_valid));
  assert_slave_b_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_slave |-> flag_b_out);
  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !rx_ld && !pwr_dn) |=> (rx_valid && $stable(rx_data)));
endmodule

// File: tb/tb_cxf_stage.sv
`timescale 1ns/1ps
module tb_cxf_stage;
  localparam int W  = 16;
  localparam int NS = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, pd_m = 1'b0;
  tri [W-1:0] bus, sbus;
  int checks = 0, errors = 0;

  logic m_txv = 0, m_txr, m_rxv, m_rxr = 1, m_rxb, m_fa_out, m_fb_out, m_fb_in = 1;
  logic [W-1:0] m_txd = '0, m_rxd;
  logic [NS-1:0] s_txv = '0, s_txr, s_rxv, s_rxr = '1, s_rxb, s_fa_out, s_fb_out;
  wire  [NS-1:0] s_fb_in;
  logic [W-1:0] s_txd [NS];
  logic [W-1:0] s_rxd [NS];
  logic o_txv = 0, o_txr, o_rxv, o_rxb, o_fa_out, o_fb_out;
  logic [W-1:0] o_txd = '0, o_rxd;

  cxf_stage dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pd_m), .is_slave(1'b0),
    .tx_valid(m_txv), .tx_ready(m_txr), .tx_data(m_txd),
    .rx_valid(m_rxv), .rx_ready(m_rxr), .rx_data(m_rxd), .rx_bcast(m_rxb),
    .cas_bus(bus), .flag_a_in(s_fa_out[NS-1]), .flag_b_in(m_fb_in),
    .flag_a_out(m_fa_out), .flag_b_out(m_fb_out)
  );

  for (genvar g = 0; g < NS; g++) begin : g_sl
    if (g == 0) begin : g_first
      assign s_fb_in[g] = m_fb_out;
    end else begin : g_next
      assign s_fb_in[g] = s_fa_out[g-1];
    end
    initial s_txd[g] = '0;
    cxf_stage sl (
      .clk(clk), .rst_n(rst_n), .pwr_dn(1'b0), .is_slave(1'b1),
      .tx_valid(s_txv[g]), .tx_ready(s_txr[g]), .tx_data(s_txd[g]),
      .rx_valid(s_rxv[g]), .rx_ready(s_rxr[g]), .rx_data(s_rxd[g]), .rx_bcast(s_rxb[g]),
      .cas_bus(bus), .flag_a_in(m_fa_out), .flag_b_in(s_fb_in[g]),
      .flag_a_out(s_fa_out[g]), .flag_b_out(s_fb_out[g])
    );
  end

  cxf_stage solo (
    .clk(clk), .rst_n(rst_n), .pwr_dn(1'b0), .is_slave(1'b0),
    .tx_valid(o_txv), .tx_ready(o_txr), .tx_data(o_txd),
    .rx_valid(o_rxv), .rx_ready(1'b1), .rx_data(o_rxd), .rx_bcast(o_rxb),
    .cas_bus(sbus), .flag_a_in(o_fb_out), .flag_b_in(1'b1),
    .flag_a_out(o_fa_out), .flag_b_out(o_fb_out)
  );

  // ---------------- monitor ----------------
  logic [W:0] mlog [8];
  logic [W:0] slog [NS][8];
  logic [W:0] olog [8];
  int mn = 0, on = 0, o_fa_cnt = 0, o_fb_cnt = 0, run = 0, drive_seen = 0;
  int sn [NS];
  bit prev_low = 0, mon_skip = 0;

  initial for (int i = 0; i < NS; i++) sn[i] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int lows;
      bit driven, xseen;
      driven = (bus !== {W{1'bz}});
      xseen = 1'b0;
      for (int b = 0; b < W; b++) if (bus[b] === 1'bx) xseen = 1'b1;
      if (xseen) begin
        errors++;
        $display("FAIL R10 bus contention: actual %b expected no x", bus);
      end
      if (driven) begin
        run++;
        drive_seen++;
      end else begin
        if (run != 0 && !mon_skip) begin
          checks++;
          if (run != 4) begin
            errors++;
            $display("FAIL R2 drive length: actual %0d expected %0d", run, 4);
          end
        end
        run = 0;
      end
      lows = $countones({~m_fa_out, ~m_fb_out, ~s_fa_out});
      if (lows > 0 && !mon_skip) begin
        checks++;
        if (run != 3 || lows != 1 || prev_low) begin
          errors++;
          $display("FAIL R2 flag pulse: actual run %0d lows %0d prev %0d expected run 3 lows 1 prev 0",
                   run, lows, prev_low);
        end
      end
      prev_low = (lows > 0);
      if (m_rxv && m_rxr && mn < 8) begin mlog[mn] = {m_rxb, m_rxd}; mn++; end
      for (int i = 0; i < NS; i++)
        if (s_rxv[i] && s_rxr[i] && sn[i] < 8) begin slog[i][sn[i]] = {s_rxb[i], s_rxd[i]}; sn[i]++; end
      if (o_rxv && on < 8) begin olog[on] = {o_rxb, o_rxd}; on++; end
      if (!o_fa_out) o_fa_cnt++;
      if (!o_fb_out) o_fb_cnt++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_m(input logic [W-1:0] d);
    @(negedge clk); m_txv = 1; m_txd = d;
    while (!m_txr) @(negedge clk);
    @(negedge clk); m_txv = 0;
  endtask

  task automatic send_s(input int i, input logic [W-1:0] d);
    @(negedge clk); s_txv[i] = 1; s_txd[i] = d;
    while (!s_txr[i]) @(negedge clk);
    @(negedge clk); s_txv[i] = 0;
  endtask

  task automatic clear_logs();
    mn = 0;
    for (int i = 0; i < NS; i++) sn[i] = 0;
  endtask

  logic [W-1:0] rw [NS];

  function automatic logic [W-1:0] slave_word(input int i, input logic [NS-1:0] ld);
    return ld[i] ? rw[i] : '0;
  endfunction

  function automatic logic [W-1:0] upstream_word(input int i, input logic [W-1:0] mw, input logic [NS-1:0] ld);
    return (i == 0) ? mw : slave_word(i - 1, ld);
  endfunction

  task automatic run_ring(input logic [W-1:0] mw, input logic [NS-1:0] ld);
    int d0;
    clear_logs();
    d0 = drive_seen;
    for (int i = 0; i < NS; i++) if (ld[i]) send_s(i, rw[i]);
    repeat (10) @(negedge clk);
    chk("R4", "slave drove without token", drive_seen, d0);
    for (int i = 0; i < NS; i++) if (ld[i]) chk("R8", "tx_ready while word held", s_txr[i], 0);
    send_m(mw);
    repeat (80) @(negedge clk);
  endtask

  task automatic check_ring(input logic [W-1:0] mw, input logic [NS-1:0] ld);
    logic [W-1:0] last;
    last = slave_word(NS - 1, ld);
    chk("R5", "master rx count", mn, 1);
    chk("R5", "master returned word", mlog[0], {1'b0, last});
    for (int i = 0; i < NS; i++) begin
      chk("R4", "slave rx count", sn[i], 2);
      chk("R4", "slave upstream word", slog[i][0], {1'b0, upstream_word(i, mw, ld)});
      chk("R6", "slave broadcast word", slog[i][1], {1'b1, last});
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1", "flag_a_out in reset", m_fa_out, 1);
    chk("R1", "flag_b_out in reset", m_fb_out, 1);
    chk("R1", "bus released in reset", (bus === {W{1'bz}}), 1);
    chk("R1", "rx_valid in reset", m_rxv, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R8", "tx_ready after reset", m_txr, 1);

    // directed: all slaves loaded
    rw[0] = 16'h1111; rw[1] = 16'h2222; rw[2] = 16'h3333;
    run_ring(16'hA5C3, 3'b111);
    check_ring(16'hA5C3, 3'b111);

    // directed: no slave loaded, zeros forwarded
    run_ring(16'h8001, 3'b000);
    check_ring(16'h8001, 3'b000);

    // R3: stray pulse on master's second flag input
    begin
      int d0;
      clear_logs();
      d0 = drive_seen;
      @(negedge clk); m_fb_in = 0;
      @(negedge clk); m_fb_in = 1;
      repeat (20) @(negedge clk);
      chk("R3", "master drove on flag_b_in pulse", drive_seen, d0);
      chk("R3", "master rx on flag_b_in pulse", mn, 0);
    end

    // R7: consumer not ready for two words; broadcast replaces upstream
    rw[2] = 16'h5A5A;
    s_rxr[0] = 0;
    run_ring(16'h0F0F, 3'b100);
    chk("R7", "held rx_valid", s_rxv[0], 1);
    chk("R7", "replaced rx_data", s_rxd[0], 16'h5A5A);
    chk("R7", "replaced rx_bcast", s_rxb[0], 1);
    chk("R7", "nothing taken while not ready", sn[0], 0);
    @(negedge clk); s_rxr[0] = 1;
    repeat (3) @(negedge clk);
    chk("R7", "word taken after ready", sn[0], 1);

    // R1: power-down in the middle of a master transfer
    begin
      int d0;
      clear_logs();
      mon_skip = 1;
      send_m(16'hDEAD);
      @(posedge clk); #1 pd_m = 1;
      #0.5;
      chk("R1", "bus released in power-down", (bus === {W{1'bz}}), 1);
      chk("R1", "flag_a_out in power-down", m_fa_out, 1);
      chk("R1", "flag_b_out in power-down", m_fb_out, 1);
      chk("R1", "tx_ready in power-down", m_txr, 0);
      repeat (5) @(negedge clk);
      pd_m = 0;
      repeat (3) @(negedge clk);
      mon_skip = 0;
      d0 = drive_seen;
      repeat (40) @(negedge clk);
      chk("R1", "idle after power-down", drive_seen, d0);
      chk("R1", "no return after power-down", mn, 0);
      chk("R1", "tx_ready after power-down", m_txr, 1);
    end

    // random rounds
    for (int r = 0; r < 12; r++) begin
      logic [W-1:0] mw;
      logic [NS-1:0] ld;
      mw = W'($urandom);
      ld = NS'($urandom);
      for (int i = 0; i < NS; i++) rw[i] = W'($urandom);
      run_ring(mw, ld);
      check_ring(mw, ld);
    end

    // R9: single-chip loopback
    for (int k = 0; k < 3; k++) begin
      logic [W-1:0] w;
      w = W'($urandom) | 16'h8000;
      on = 0; o_fa_cnt = 0; o_fb_cnt = 0;
      @(negedge clk); o_txv = 1; o_txd = w;
      while (!o_txr) @(negedge clk);
      @(negedge clk); o_txv = 0;
      repeat (40) @(negedge clk);
      chk("R9", "loopback rx count", on, 1);
      chk("R9", "loopback word", olog[0], {1'b0, w});
      chk("R9", "loopback flag_a pulses", o_fa_cnt, 1);
      chk("R9", "loopback flag_b pulses", o_fb_cnt, 1);
    end

    chk("R10", "bus left released", (bus === {W{1'bz}}), 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule